// File: doc/BRIEF.md
# Shared-Bus Requester Handshake Controller

This block lets a secondary processor reach a memory region that belongs to a primary bus master. The local side presents one request at a time with an address, write data, a direction bit, a flag that says whether the address lies in the shared region, and a flag that says whether the shared target is synchronous DRAM. The block raises a bus request toward the primary master and samples the grant on falling clock edges. Once it has the bus, it opens a one-clock external access cycle on a rising edge. It then either completes the write or counts out the read latency and captures the returned data. Finally it gives the bus back.

The read path runs through buffers in both directions, so by default the effective read latency is the device CAS latency plus two cycles. A parameter removes this offset for slow clocks. When the target is synchronous DRAM, the request stays asserted for the auto-precharge time after the access. Refresh requests and requests for the privately owned region do not start a bus handshake.

Top module: `shbus_req`

## Requirements
- R1: After reset `bus_req`, `busy`, `done` and `cyc_start` are low. A shared-region request (`req_valid` and `req_shared` high while `busy` is low) is accepted on a rising edge, which sets `busy` on that edge. `bus_req` then rises on the following falling edge.
- R2: `bus_grant` is sampled only on falling edges. `cyc_start` is high for exactly one clock, beginning at the rising edge that follows a falling edge on which the grant was high. A grant pulse that falls between two falling edges never starts a cycle.
- R3: For a target that is not synchronous DRAM, `bus_req` is negated on the first falling edge after `done` rises. `busy` falls only after a falling edge has sampled the grant low.
- R4: With `LAT_COMP`=1, a read captures `ext_rdata` on the rising edge `CAS_LAT`+2 clocks after the edge that started the cycle. `done` is high in the clock after that edge and `rdata` holds the captured value.
- R5: For a synchronous DRAM target (`req_sdram`=1), `bus_req` stays asserted for `TPRE` further clocks after `done` rises before it is negated.
- R6: With `LAT_COMP`=0, the read capture happens `CAS_LAT` clocks after the start edge.
- R7: `refresh_req` has no effect. While idle it raises none of `bus_req`, `busy` or `cyc_start`.
- R8: A request with `req_shared`=0 is ignored. `busy`, `bus_req` and `cyc_start` stay low.
- R9: During the access cycle `ext_addr`, `ext_we` and `ext_wdata` carry the accepted request. A write raises `done` one clock after the start edge. `done` is a single-clock pulse per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; falling edge for handshake, rising edge for cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local access request |
| req_shared | input | 1 | Request targets the shared region |
| req_write | input | 1 | 1 write, 0 read |
| req_sdram | input | 1 | Shared target is synchronous DRAM |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| refresh_req | input | 1 | Refresh request for the shared region (ignored) |
| bus_req | output | 1 | Bus request to primary master |
| bus_grant | input | 1 | Bus grant from primary master |
| cyc_start | output | 1 | External access cycle strobe |
| ext_addr | output | AW | External address |
| ext_we | output | 1 | External write enable |
| ext_wdata | output | DW | External write data |
| ext_rdata | input | DW | External read data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Captured read data |

## Verification
The hardest case to reach is a grant that rises and falls between two falling edges. The rising-edge logic never sees such a grant, so it must not start a cycle. The bench drives two such half-clock pulses after the request is raised and only then gives a real grant. It then checks that exactly one cycle starts, one clock after the real grant. Read data is driven as a value that changes every clock, so a capture one cycle early or late shows up as wrong data. A second instance with the compensation turned off shares the same stimulus.

// File: rtl/shbus_req.sv
module shbus_req #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int CAS_LAT  = 2,
  parameter int LAT_COMP = 1,
  parameter int TPRE     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_shared,
  input  logic          req_write,
  input  logic          req_sdram,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          refresh_req,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          cyc_start,
  output logic [AW-1:0] ext_addr,
  output logic          ext_we,
  output logic [DW-1:0] ext_wdata,
  input  logic [DW-1:0] ext_rdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata
);
  localparam int LAT_EFF = CAS_LAT + ((LAT_COMP != 0) ? 2 : 0);
  localparam int CW = $clog2(LAT_EFF + 1) + 1;
  localparam int PW = $clog2(TPRE + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_CYC, S_LAT, S_PRE, S_REL} st_t;
  st_t st;

  logic          gnt_s, breq_q, wr_q, sd_q, done_q;
  logic [CW-1:0] lc;
  logic [PW-1:0] pc;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q, rd_q;

  wire want    = (st == S_REQ) || (st == S_CYC) || (st == S_LAT) || (st == S_PRE);
  wire capture = !wr_q && (lc == CW'(LAT_EFF)) && ((st == S_CYC) || (st == S_LAT));
  wire finish  = ((st == S_CYC) && wr_q) || capture;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      breq_q <= 1'b0;
      gnt_s  <= 1'b0;
    end else begin
      breq_q <= want;
      gnt_s  <= bus_grant;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      lc     <= '0;
      pc     <= '0;
      wr_q   <= 1'b0;
      sd_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (capture) rd_q <= ext_rdata;
      case (st)
        S_IDLE:
          if (req_valid && req_shared) begin
            addr_q <= req_addr;
            wd_q   <= req_wdata;
            wr_q   <= req_write;
            sd_q   <= req_sdram;
            st     <= S_REQ;
          end
        S_REQ:
          if (gnt_s) begin
            lc <= CW'(1);
            st <= S_CYC;
          end
        S_CYC, S_LAT: begin
          lc <= lc + CW'(1);
          if (finish) begin
            pc <= '0;
            st <= sd_q ? S_PRE : S_REL;
          end else begin
            st <= S_LAT;
          end
        end
        S_PRE:
          if (pc == PW'(TPRE - 1)) st <= S_REL;
          else pc <= pc + PW'(1);
        S_REL:
          if (!gnt_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end

  assign bus_req   = breq_q;
  assign cyc_start = (st == S_CYC);
  assign ext_addr  = addr_q;
  assign ext_we    = wr_q;
  assign ext_wdata = wd_q;
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign rdata     = rd_q;

  a_r2_no_stale_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REQ && !gnt_s) |=> !cyc_start);
  a_r2_cycle_has_bus: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> bus_req);
  a_r2_one_clock_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start);
  a_r3_idle_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);
  a_r5_precharge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sd_q) |-> bus_req);
  a_r7_refresh_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && refresh_req && !(req_valid && req_shared)) |=> !busy);
  a_r8_private_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !req_shared) |=> !busy);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_shbus_req.sv
`timescale 1ns/1ps
module sim_shbus_req;
  localparam int AW = 16, DW = 16, CAS = 2, TPRE = 3;
  localparam int LEFF = CAS + 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_shared = 0, req_write = 0, req_sdram = 0, refresh_req = 0;
  logic bus_grant = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, ext_rdata = '0;
  logic bus_req, cyc_start, ext_we, busy, done;
  logic [AW-1:0] ext_addr;
  logic [DW-1:0] ext_wdata, rdata;
  logic bus_req1, cyc1, we1, busy1, done1;
  logic [AW-1:0] addr1;
  logic [DW-1:0] wd1, rdata1;

  always #2.5 clk = ~clk;

  shbus_req #(.AW(AW), .DW(DW), .CAS_LAT(CAS), .LAT_COMP(1), .TPRE(TPRE)) u0 (
    .clk, .rst_n, .req_valid, .req_shared, .req_write, .req_sdram, .req_addr, .req_wdata,
    .refresh_req, .bus_req, .bus_grant, .cyc_start, .ext_addr, .ext_we, .ext_wdata,
    .ext_rdata, .busy, .done, .rdata);

  shbus_req #(.AW(AW), .DW(DW), .CAS_LAT(CAS), .LAT_COMP(0), .TPRE(TPRE)) u1 (
    .clk, .rst_n, .req_valid, .req_shared, .req_write, .req_sdram, .req_addr, .req_wdata,
    .refresh_req, .bus_req(bus_req1), .bus_grant, .cyc_start(cyc1), .ext_addr(addr1),
    .ext_we(we1), .ext_wdata(wd1), .ext_rdata, .busy(busy1), .done(done1), .rdata(rdata1));

  int n_chk = 0, n_fail = 0, cnt = 0;
  int t_cyc, n_cyc, t_done, n_done, t_done1;
  logic [AW-1:0] seen_addr;
  logic [DW-1:0] seen_wd, got_rd, got_rd1;
  logic seen_we;

  function automatic logic [DW-1:0] pat(int c);
    return DW'(c * 40503 + 7);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    cnt = cnt + 1;
    #1;
    if (cyc_start) begin
      t_cyc = cnt; n_cyc++;
      seen_addr = ext_addr; seen_wd = ext_wdata; seen_we = ext_we;
    end
    if (done) begin t_done = cnt; n_done++; got_rd = rdata; end
    if (done1) begin t_done1 = cnt; got_rd1 = rdata1; end
    ext_rdata = pat(cnt);
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic run(bit wr, bit sd, logic [AW-1:0] a, logic [DW-1:0] d, int gdel, bit glitch);
    int g, fall, guard;
    t_cyc = -1; n_cyc = 0; t_done = -1; n_done = 0; t_done1 = -1;
    tick();
    req_valid = 1; req_shared = 1; req_write = wr; req_sdram = sd; req_addr = a; req_wdata = d;
    tick();
    req_valid = 0;
    chk(busy == 1 && bus_req == 0, "R1 accept, request waits for falling edge", bus_req, 0);
    tick();
    chk(bus_req == 1, "R1 request raised on falling edge", bus_req, 1);
    if (glitch) begin
      for (int i = 0; i < 2; i++) begin
        @(posedge clk); #0.5 bus_grant = 1; #1 bus_grant = 0;
      end
      tick();
      chk(n_cyc == 0, "R2 grant glitch between falling edges ignored", n_cyc, 0);
    end
    repeat (gdel) tick();
    tick();
    bus_grant = 1; g = cnt;
    guard = 0;
    do begin tick(); guard++; end while (bus_req && guard < 100);
    fall = cnt;
    bus_grant = 0;
    guard = 0;
    while (busy && guard < 100) begin tick(); guard++; end
    tick();
    chk(n_cyc == 1, "R2 exactly one access cycle", n_cyc, 1);
    chk(t_cyc == g + 1, "R2 cycle starts after sampled grant", t_cyc - g, 1);
    chk(seen_addr == a && seen_we == wr && (!wr || seen_wd == d), "R9 access fields", seen_addr, a);
    chk(n_done == 1, "R9 done single pulse", n_done, 1);
    if (wr) chk(t_done == t_cyc + 1, "R9 write done timing", t_done - t_cyc, 1);
    else begin
      chk(t_done == t_cyc + LEFF, "R4 compensated read latency", t_done - t_cyc, LEFF);
      chk(got_rd == pat(t_done - 1), "R4 captured read data", got_rd, pat(t_done - 1));
      chk(t_done1 == t_cyc + CAS, "R6 uncompensated read latency", t_done1 - t_cyc, CAS);
      chk(got_rd1 == pat(t_done1 - 1), "R6 uncompensated read data", got_rd1, pat(t_done1 - 1));
    end
    if (sd) chk(fall == t_done + 1 + TPRE, "R5 precharge hold", fall - t_done, 1 + TPRE);
    else    chk(fall == t_done + 1, "R3 release after done", fall - t_done, 1);
    chk(busy == 0 && bus_req == 0, "R3 busy drops after grant low", busy, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cnt, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tick();
    chk(!bus_req && !busy && !done && !cyc_start, "R1 reset state", bus_req | busy | done, 0);

    refresh_req = 1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(!bus_req && !busy && !cyc_start, "R7 refresh ignored", busy | bus_req, 0);
    end
    refresh_req = 0;

    req_valid = 1; req_shared = 0; req_write = 0; req_addr = 16'h1234;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(!bus_req && !busy && !cyc_start, "R8 private request ignored", busy | bus_req, 0);
    end
    req_valid = 0;

    run(1, 0, 16'h00A5, 16'hBEEF, 0, 0);
    run(0, 1, 16'h7F01, 16'h0000, 2, 1);
    run(0, 0, 16'h3C3C, 16'h0000, 1, 0);
    run(1, 1, 16'hFFFE, 16'h5A5A, 0, 1);
    run(0, 1, 16'h0001, 16'h0000, 4, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule